// File: doc/BRIEF.md
# Block-Transfer Read Slave for an Asynchronous Backplane Bus

This block is a bus slave that serves 32-bit block-transfer reads from a small on-chip word memory. A master places a 32-bit address, a 6-bit address-modifier code and the longword qualifier on the bus, then lowers the address strobe. The slave brings the strobes into its local clock domain and captures the address when the strobe falls. It then decides whether the cycle is meant for this card. For a cycle that targets it, the slave serves one longword per data-strobe beat. It drives the word on all 32 data lines, acknowledges it, and moves its internal word pointer forward by one for the next beat.

Whether the slave answers depends on three configuration values: a card-enable flag, a compare byte for the top address byte, and the address-modifier code to accept. All three are set by byte writes on a configuration port. The same port also writes bytes straight into the word memory, which is how the memory is filled before use. The configuration port is a valid/ready stream. A write is taken on a clock edge where both valid and ready are high. The writer must hold the address and the data steady until then. Ready stays low while the synchronised address strobe is asserted and while a bus cycle is being finished. So configuration can never change in the middle of a transfer, and it never competes with a read for the memory.

The data and acknowledge outputs each come with an output-enable. An enable that is low means the line is left undriven.

Top module: `vbr_blt_slave`

## Requirements
- R1: After reset, bus_ack_oe and bus_dout_oe are 0, bus_ack_n is 1 and cfg_ready is 1.
- R2: Bit 4 of the configuration byte at offset 0x7FFFB is the card enable. While it is 0, no bus cycle is answered: bus_ack_oe and bus_dout_oe stay 0.
- R3: The byte at offset 0x7FF63 is compared with address bits 31:24 at the falling address strobe. On a mismatch the cycle is ignored. Address bits 23:8 do not take part in the decode.
- R4: Bits 7:2 of the byte at offset 0x7FF6F hold the accepted address-modifier code. A cycle with any other code is ignored.
- R5: A cycle whose start address has bits 1:0 not equal to 00, or whose longword qualifier bus_lw_n is high, is ignored.
- R6: A beat begins only when both data-strobe bits are low (bus_dstb_n = 00). With only one of them low, the slave does not respond.
- R7: Beat k of an accepted cycle (counted from 0) returns the memory word at index (start address bits 7:2 + k) modulo 64 on all 32 lines of bus_dout.
- R8: bus_dout_oe rises at least one clock before the acknowledge goes active (bus_ack_oe = 1 and bus_ack_n = 0). bus_dout stays unchanged while the acknowledge is active.
- R9: After both data strobes rise, the acknowledge goes inactive within 4 clocks. It is driven high for one clock before bus_ack_oe falls, and the data lines are released together with it.
- R10: Releasing the address strobe clears the beat count, so a new cycle starts at its own address.
- R11: A configuration write to an offset below 256 writes one byte of the memory: word offset[7:2], with lane offset[1:0] = 0 selecting bits 31:24 and lane 3 selecting bits 7:0. cfg_ready is low while an address strobe is being handled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cfg_valid | input | 1 | Configuration write request |
| cfg_ready | output | 1 | Configuration write can be accepted |
| cfg_addr | input | 19 | Configuration byte offset |
| cfg_data | input | 8 | Configuration byte value |
| bus_addr | input | 32 | Bus address |
| bus_am | input | 6 | Bus address-modifier code |
| bus_astb_n | input | 1 | Address strobe, active low, asynchronous |
| bus_dstb_n | input | 2 | Data strobes, active low, asynchronous |
| bus_lw_n | input | 1 | Longword qualifier, active low |
| bus_dout | output | 32 | Read data toward the bus |
| bus_dout_oe | output | 1 | Drive enable for bus_dout |
| bus_ack_n | output | 1 | Data acknowledge level, active low |
| bus_ack_oe | output | 1 | Drive enable for bus_ack_n |

## Verification
If the word pointer is wrong, the error shows up on the very next acknowledged beat as a wrong word. That is most visible in a burst that wraps from index 63 to 0, and in a second burst that must begin again from its own address. If the decode state is wrong, the fault appears within the first beat: an ignored cycle receives an acknowledge, or an accepted cycle never gets one. If the handshake sequencing is wrong, the acknowledge comes without data already on the bus, or it is not released within a few clocks of the strobes rising. In both cases the beat boundary where it happens is visible.

// File: rtl/vbr_pkg.sv
`timescale 1ns/1ps
package vbr_pkg;
  // bus data width is fixed by the 2-bit byte-lane field
  localparam int DW    = 32;
  localparam int LANES = DW / 8;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for an address strobe
    ST_SKIP,   // cycle not for this card, wait for strobe release
    ST_SEL,    // selected, waiting for a beat
    ST_FETCH,  // memory read in flight
    ST_LOAD,   // data on the lines, acknowledge next
    ST_ACK,    // acknowledge active, waiting for strobe release
    ST_REL     // acknowledge driven high for one clock
  } beat_state_e;
endpackage

// File: rtl/vbr_sync.sv
`timescale 1ns/1ps
module vbr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/vbr_cfg_regs.sv
`timescale 1ns/1ps
module vbr_cfg_regs #(
  parameter int CFG_AW = 19,
  parameter int DEPTH  = 64,
  parameter logic [CFG_AW-1:0] OFS_ENABLE = 19'h7FFFB,
  parameter logic [CFG_AW-1:0] OFS_WINDOW = 19'h7FF63,
  parameter logic [CFG_AW-1:0] OFS_AMCODE = 19'h7FF6F,
  localparam int IW = $clog2(DEPTH),
  localparam int LANES = vbr_pkg::LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              card_en,
  output logic [7:0]        win_byte,
  output logic [5:0]        am_code,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [IW-1:0]     mem_idx
);
  localparam int MEM_BYTES = DEPTH * LANES;

  logic in_mem;
  assign in_mem  = wr_addr < CFG_AW'(MEM_BYTES);
  assign mem_we  = wr_fire && in_mem;
  assign mem_idx = wr_addr[IW+1:2];

  // lane 0 of the offset is the most significant byte of the word
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign mem_be[l] = mem_we && (wr_addr[1:0] == 2'(LANES - 1 - l));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      card_en  <= 1'b0;
      win_byte <= 8'h00;
      am_code  <= 6'h00;
    end else if (wr_fire) begin
      if (wr_addr == OFS_ENABLE) card_en  <= wr_data[4];
      if (wr_addr == OFS_WINDOW) win_byte <= wr_data;
      if (wr_addr == OFS_AMCODE) am_code  <= wr_data[7:2];
    end
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^wr_data[1:0];
endmodule

// File: rtl/vbr_ram.sv
`timescale 1ns/1ps
module vbr_ram #(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int DW = vbr_pkg::DW,
  localparam int LANES = vbr_pkg::LANES
) (
  input  logic             clk,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic             re,
  input  logic [IW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (be[l]) mem[addr][l*8 +: 8] <= wdata[l*8 +: 8];
      end
    end
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/vbr_beat_engine.sv
`timescale 1ns/1ps
module vbr_beat_engine
  import vbr_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          astb_s,
  input  logic [1:0]    dstb_s,
  input  logic [31:0]   bus_addr,
  input  logic [5:0]    bus_am,
  input  logic          bus_lw_n,
  input  logic          card_en,
  input  logic [7:0]    win_byte,
  input  logic [5:0]    am_code,
  output logic          ram_re,
  output logic [IW-1:0] ram_idx,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          ack_n,
  output logic          ack_oe,
  output logic          idle,
  output logic [1:0]    start_lo
);
  beat_state_e   state;
  logic          astb_q;
  logic          astb_fall;
  logic          hit;
  logic [IW-1:0] base_idx;
  logic [IW-1:0] beat_cnt;
  logic          beat_go;

  assign astb_fall = astb_q && !astb_s;
  assign hit = card_en
            && (bus_am == am_code)
            && (bus_addr[31:24] == win_byte)
            && (bus_addr[1:0] == 2'b00)
            && !bus_lw_n;

  assign beat_go = (state == ST_SEL) && !astb_s && (dstb_s == 2'b00);
  assign ram_re  = beat_go;
  assign ram_idx = base_idx + beat_cnt;
  assign idle    = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      astb_q   <= 1'b1;
      base_idx <= '0;
      beat_cnt <= '0;
      start_lo <= 2'b00;
      dout     <= '0;
      dout_oe  <= 1'b0;
      ack_n    <= 1'b1;
      ack_oe   <= 1'b0;
    end else begin
      astb_q <= astb_s;
      case (state)
        ST_IDLE: begin
          if (astb_fall) begin
            base_idx <= bus_addr[IW+1:2];
            start_lo <= bus_addr[1:0];
            beat_cnt <= '0;
            state    <= hit ? ST_SEL : ST_SKIP;
          end
        end
        ST_SKIP: begin
          if (astb_s) state <= ST_IDLE;
        end
        ST_SEL: begin
          if (astb_s) begin
            beat_cnt <= '0;
            state    <= ST_IDLE;
          end else if (beat_go) begin
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          dout    <= ram_rdata;
          dout_oe <= 1'b1;
          state   <= ST_LOAD;
        end
        ST_LOAD: begin
          ack_n  <= 1'b0;
          ack_oe <= 1'b1;
          state  <= ST_ACK;
        end
        ST_ACK: begin
          if (dstb_s == 2'b11) begin
            ack_n <= 1'b1;
            state <= ST_REL;
          end
        end
        ST_REL: begin
          ack_oe   <= 1'b0;
          dout_oe  <= 1'b0;
          beat_cnt <= beat_cnt + 1'b1;
          state    <= ST_SEL;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic unused_addr_bits;
  assign unused_addr_bits = ^bus_addr[23:IW+2];
endmodule

// File: rtl/vbr_blt_slave.sv
`timescale 1ns/1ps
module vbr_blt_slave #(
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_AW      = 19,
  parameter logic [CFG_AW-1:0] OFS_ENABLE = 19'h7FFFB,
  parameter logic [CFG_AW-1:0] OFS_WINDOW = 19'h7FF63,
  parameter logic [CFG_AW-1:0] OFS_AMCODE = 19'h7FF6F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_data,
  input  logic [31:0]       bus_addr,
  input  logic [5:0]        bus_am,
  input  logic              bus_astb_n,
  input  logic [1:0]        bus_dstb_n,
  input  logic              bus_lw_n,
  output logic [31:0]       bus_dout,
  output logic              bus_dout_oe,
  output logic              bus_ack_n,
  output logic              bus_ack_oe
);
  import vbr_pkg::*;
  localparam int IW = $clog2(DEPTH);

  logic [2:0]       strb_s;
  logic             astb_s;
  logic [1:0]       dstb_s;
  logic             cfg_fire;
  logic             card_en;
  logic [7:0]       win_byte;
  logic [5:0]       am_code;
  logic             mem_we;
  logic [LANES-1:0] mem_be;
  logic [IW-1:0]    mem_idx;
  logic             ram_re;
  logic [IW-1:0]    rd_idx;
  logic [IW-1:0]    ram_addr;
  logic [DW-1:0]    ram_rdata;
  logic             eng_idle;
  logic [1:0]       start_lo;

  vbr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_astb_n, bus_dstb_n}),
    .q     (strb_s)
  );
  assign astb_s = strb_s[2];
  assign dstb_s = strb_s[1:0];

  assign cfg_ready = eng_idle && astb_s;
  assign cfg_fire  = cfg_valid && cfg_ready;

  vbr_cfg_regs #(
    .CFG_AW(CFG_AW), .DEPTH(DEPTH),
    .OFS_ENABLE(OFS_ENABLE), .OFS_WINDOW(OFS_WINDOW), .OFS_AMCODE(OFS_AMCODE)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (cfg_fire),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_data),
    .card_en  (card_en),
    .win_byte (win_byte),
    .am_code  (am_code),
    .mem_we   (mem_we),
    .mem_be   (mem_be),
    .mem_idx  (mem_idx)
  );

  // reads happen only while not idle, writes only while idle
  assign ram_addr = ram_re ? rd_idx : mem_idx;

  vbr_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .be    (mem_be),
    .re    (ram_re),
    .addr  (ram_addr),
    .wdata ({LANES{cfg_data}}),
    .rdata (ram_rdata)
  );

  vbr_beat_engine #(.DEPTH(DEPTH)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .astb_s    (astb_s),
    .dstb_s    (dstb_s),
    .bus_addr  (bus_addr),
    .bus_am    (bus_am),
    .bus_lw_n  (bus_lw_n),
    .card_en   (card_en),
    .win_byte  (win_byte),
    .am_code   (am_code),
    .ram_re    (ram_re),
    .ram_idx   (rd_idx),
    .ram_rdata (ram_rdata),
    .dout      (bus_dout),
    .dout_oe   (bus_dout_oe),
    .ack_n     (bus_ack_n),
    .ack_oe    (bus_ack_oe),
    .idle      (eng_idle),
    .start_lo  (start_lo)
  );
endmodule

// File: rtl/vbr_blt_checker.sv
`timescale 1ns/1ps
module vbr_blt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ack_n,
  input logic        ack_oe,
  input logic [31:0] dout,
  input logic        dout_oe,
  input logic        cfg_ready,
  input logic        card_en,
  input logic [1:0]  start_lo
);
  logic ack_on;
  assign ack_on = ack_oe && !ack_n;

  AST_DATA_LEADS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_on) |-> $past(dout_oe) && $stable(dout)); // R8
  AST_DATA_HELD_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_on && $past(ack_on) |-> $stable(dout) && dout_oe); // R8
  AST_ACK_HIGH_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_oe) |-> $past(ack_n)); // R9
  AST_DRIVE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> card_en); // R2
  AST_DRIVE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> start_lo == 2'b00); // R5
  AST_NO_CFG_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe || ack_oe) |-> !cfg_ready); // R11
endmodule

bind vbr_blt_slave vbr_blt_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack_n     (bus_ack_n),
  .ack_oe    (bus_ack_oe),
  .dout      (bus_dout),
  .dout_oe   (bus_dout_oe),
  .cfg_ready (cfg_ready),
  .card_en   (card_en),
  .start_lo  (start_lo)
);

// File: tb/sim_vbr_blt_slave.sv
`timescale 1ns/1ps
module sim_vbr_blt_slave;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_valid;
  logic        cfg_ready;
  logic [18:0] cfg_addr;
  logic [7:0]  cfg_data;
  logic [31:0] bus_addr;
  logic [5:0]  bus_am;
  logic        bus_astb_n;
  logic [1:0]  bus_dstb_n;
  logic        bus_lw_n;
  logic [31:0] bus_dout;
  logic        bus_dout_oe;
  logic        bus_ack_n;
  logic        bus_ack_oe;

  always #2 clk = ~clk;

  vbr_blt_slave u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .bus_addr(bus_addr), .bus_am(bus_am), .bus_astb_n(bus_astb_n),
    .bus_dstb_n(bus_dstb_n), .bus_lw_n(bus_lw_n),
    .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe),
    .bus_ack_n(bus_ack_n), .bus_ack_oe(bus_ack_oe)
  );

  localparam logic [5:0] AM_OK  = 6'h0B;
  localparam logic [5:0] AM_BAD = 6'h09;

  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  logic [31:0] exp_mem [64];
  logic [31:0] sbq [$];

  function automatic logic [31:0] pat(int i);
    return {8'(i * 3 + 1), 8'(i ^ 'h5A), 8'(8'hC0 + i), 8'(i)};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare each newly acknowledged beat with the scoreboard head
  logic        prev_act = 1'b0;
  logic        prev_doe = 1'b0;
  logic [31:0] prev_dat = '0;
  always @(negedge clk) begin
    logic        act;
    logic [31:0] e;
    act = bus_ack_oe && !bus_ack_n;
    if (rst_n && act && !prev_act) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R7 acknowledge with nothing expected", bus_dout, 32'h0);
      end else begin
        e = sbq.pop_front();
        chk(bus_dout == e, "R7 beat data", bus_dout, e);
      end
      chk(prev_doe && (prev_dat == bus_dout), "R8 data present before acknowledge",
          prev_dat, bus_dout);
    end
    prev_act = act;
    prev_doe = bus_dout_oe;
    prev_dat = bus_dout;
  end

  task automatic cfg_wr(logic [18:0] a, logic [7:0] d);
    @(negedge clk);
    while (!cfg_ready) @(negedge clk);
    cfg_valid = 1'b1;
    cfg_addr  = a;
    cfg_data  = d;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic start_cycle(logic [31:0] a, logic [5:0] am, logic lw);
    @(negedge clk);
    bus_addr = a;
    bus_am   = am;
    bus_lw_n = lw;
    @(negedge clk);
    bus_astb_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!cfg_ready, "R11 ready low during cycle", 32'(cfg_ready), 32'h0);
  endtask

  task automatic end_cycle();
    @(negedge clk);
    bus_astb_n = 1'b1;
    bus_addr   = 32'hDEAD_BEEF;
    repeat (5) @(negedge clk);
  endtask

  task automatic hit_beat(int idx);
    int n;
    sbq.push_back(exp_mem[idx % 64]);
    bus_dstb_n = 2'b00;
    n = 0;
    while (!(bus_ack_oe && !bus_ack_n) && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(n < 40, "R7 acknowledge arrives", 32'(n), 32'd40);
    bus_dstb_n = 2'b11;
    n = 0;
    while ((bus_ack_oe && !bus_ack_n) && n < 10) begin
      @(negedge clk);
      n++;
    end
    chk(n <= 4, "R9 acknowledge released in time", 32'(n), 32'd4);
    n = 0;
    while (bus_ack_oe && n < 10) begin
      @(negedge clk);
      n++;
    end
    chk(!bus_ack_oe && !bus_dout_oe, "R9 lines released",
        {30'h0, bus_ack_oe, bus_dout_oe}, 32'h0);
  endtask

  task automatic miss_beat(string tag);
    bus_dstb_n = 2'b00;
    repeat (20) @(negedge clk);
    chk(!bus_ack_oe && !bus_dout_oe, tag, {30'h0, bus_ack_oe, bus_dout_oe}, 32'h0);
    bus_dstb_n = 2'b11;
    repeat (4) @(negedge clk);
  endtask

  task automatic blt(logic [31:0] a, int beats);
    start_cycle(a, AM_OK, 1'b0);
    for (int k = 0; k < beats; k++) hit_beat(int'(a[7:2]) + k);
    end_cycle();
  endtask

  task automatic miss_cycle(logic [31:0] a, logic [5:0] am, logic lw, string tag);
    start_cycle(a, am, lw);
    miss_beat(tag);
    end_cycle();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    cfg_valid  = 1'b0;
    cfg_addr   = '0;
    cfg_data   = '0;
    bus_addr   = '0;
    bus_am     = '0;
    bus_astb_n = 1'b1;
    bus_dstb_n = 2'b11;
    bus_lw_n   = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!bus_ack_oe && !bus_dout_oe && bus_ack_n && cfg_ready, "R1 reset state",
        {28'h0, bus_ack_oe, bus_dout_oe, bus_ack_n, cfg_ready}, 32'h3);

    // R11 preload through byte writes, lane 0 is bits 31:24
    for (int i = 0; i < 64; i++) begin
      exp_mem[i] = pat(i);
      for (int b = 0; b < 4; b++) cfg_wr(19'(i * 4 + b), exp_mem[i][31 - 8 * b -: 8]);
    end
    cfg_wr(19'h7FF63, 8'h64);
    cfg_wr(19'h7FF6F, {AM_OK, 2'b00});

    // R2 card disabled
    miss_cycle(32'h6400_0000, AM_OK, 1'b0, "R2 ignored while disabled");
    cfg_wr(19'h7FFFB, 8'h10);

    // R7 burst from word 0
    blt(32'h6400_0000, 5);
    // R10 new cycle restarts at its own address (word 4)
    blt(32'h6400_0010, 5);
    // R7 wrap from 62 to 1
    blt(32'h6400_00F8, 4);
    // R3 middle address bits ignored
    blt(32'h6412_3404, 2);

    miss_cycle(32'h6500_0000, AM_OK, 1'b0, "R3 window mismatch ignored");
    miss_cycle(32'h6400_0000, AM_BAD, 1'b0, "R4 modifier mismatch ignored");
    miss_cycle(32'h6400_0002, AM_OK, 1'b0, "R5 unaligned start ignored");
    miss_cycle(32'h6400_0000, AM_OK, 1'b1, "R5 longword qualifier high ignored");

    // R6 a single data strobe does not start a beat
    start_cycle(32'h6400_0020, AM_OK, 1'b0);
    bus_dstb_n = 2'b10;
    repeat (20) @(negedge clk);
    chk(!bus_ack_oe && !bus_dout_oe, "R6 one strobe low (bit 0)",
        {30'h0, bus_ack_oe, bus_dout_oe}, 32'h0);
    bus_dstb_n = 2'b11;
    repeat (4) @(negedge clk);
    bus_dstb_n = 2'b01;
    repeat (20) @(negedge clk);
    chk(!bus_ack_oe && !bus_dout_oe, "R6 one strobe low (bit 1)",
        {30'h0, bus_ack_oe, bus_dout_oe}, 32'h0);
    bus_dstb_n = 2'b11;
    repeat (4) @(negedge clk);
    hit_beat(8);
    end_cycle();

    // R11 single byte overwrite, lane 1 is bits 23:16
    cfg_wr(19'(3 * 4 + 1), 8'hEE);
    exp_mem[3][23:16] = 8'hEE;
    blt(32'h6400_000C, 1);

    // R2 disable again
    cfg_wr(19'h7FFFB, 8'hEF);
    miss_cycle(32'h6400_0000, AM_OK, 1'b0, "R2 ignored after enable cleared");

    repeat (10) @(negedge clk);
    chk(sbq.size() == 0, "R7 every expected beat returned", 32'(sbq.size()), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule